// File: doc/BRIEF.md
# Parallel Timing Loop Controller (Averaging PI Filter and Direct-Calculation NCO)

This block closes the feedback path of a parallel symbol-timing loop. Every valid cycle it takes one signed timing-error value from each of `P` parallel lanes and adds all of them together. The sum drives a proportional-integral filter whose gains are powers of two. The resulting control word then places the `P` interpolation instants for the next input word, all in the same cycle.

Each lane steps the sample position forward by `N + w`. Here `N` is half the oversampling ratio and `w` is the control word, expressed as a signed fraction of one sample. Each lane position is then split into an integer basepoint and an unsigned fraction `mu`. The integer part is taken directly from the high bits of the running sum, so no countdown register or overflow comparator is needed. The fraction is the low `MUW` bits, which amounts to a shift by `MUW`. The lanes are chained: each lane starts from the position the lane before it reached. The position past the last lane, less one word of `P*N` samples, becomes lane 0 of the next word. Basepoints are therefore reported relative to the start of the current input word, modulo 2^IDXW.

Top module: `timing_loop_ctrl`

## Requirements
- R1: The proportional term is the sum of all `P` lane errors of the transaction (lane i in `err_bus[i*EW +: EW]`, two's complement), arithmetically shifted right by `KP_SH`, and not any single lane's error.
- R2: On every accepted transaction the integral becomes the previous integral plus the same sum arithmetically shifted right by `KI_SH`.
- R3: `ctrl_word` (signed, CW = MUW+1 bits, LSB = 2^-MUW sample) equals the proportional term plus the updated integral, clipped to the signed CW-bit range [-2^MUW, 2^MUW-1].
- R4: The integral register clips at the same signed CW-bit limits instead of wrapping, so it recovers at once when the error sum changes sign.
- R5: Lane positions are chained: with step_i = N*2^MUW + w + mu_i, lane i+1 gets `mu` = step_i mod 2^MUW; `frac[i*MUW +: MUW]` holds lane i's fraction.
- R6: The basepoint advance of each lane is the integer part floor(step_i / 2^MUW); `base_idx[i*IDXW +: IDXW]` holds lane i's basepoint = lane i-1 basepoint + advance, modulo 2^IDXW.
- R7: Lane 0 of a transaction starts at the last lane's position plus its step, minus P*N samples, taken from the previous transaction; after reset lane 0 starts at basepoint 0, fraction 0.
- R8: `out_valid` is high exactly in the second cycle after the cycle in which `err_valid` was high, and the outputs change only then.
- R9: When `err_valid` is low, `err_bus` has no effect: the outputs and the loop state stay unchanged.
- R10: After reset `out_valid`, `ctrl_word`, every basepoint and every fraction are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | Marks a valid set of lane errors |
| err_bus | input | P*EW | Packed signed lane errors, lane i at bits i*EW upward |
| out_valid | output | 1 | One-cycle strobe for freshly computed outputs |
| base_idx | output | P*IDXW | Packed per-lane basepoint indices |
| frac | output | P*MUW | Packed per-lane unsigned fractional intervals |
| ctrl_word | output | MUW+1 | Signed loop-filter control word |

## Verification
The bench compares every lane of every transaction against an integer model. It drives zero, constant, ramped and mixed-sign error sets, including sets whose last lane has the opposite sign to the total. A design that used only one lane's error would drift in the wrong direction on those sets.

Long runs of full-scale errors drive the integral into both clip limits and then reverse it. A wrapping integral would flip the sign of the control word there. At the negative limit the step falls to exactly one fraction, which exercises zero-advance lanes. A carry computed with the wrong word offset, or with stale fractions, shows up as a wrong lane-0 position on the next word.

Idle cycles carry garbage errors, to show that nothing moves without `err_valid`.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  // Number of levels of a binary reduction over n leaves (at least one).
  function automatic int tree_levels(input int n);
    int d;
    d = 0;
    while ((1 << d) < n) d++;
    return (d == 0) ? 1 : d;
  endfunction

  // Bits needed for an unsigned value up to and including v.
  function automatic int bits_for(input int v);
    int d;
    d = 1;
    while ((1 << d) <= v) d++;
    return d;
  endfunction

endpackage

// File: rtl/err_sum_tree.sv
module err_sum_tree
  import tlc_pkg::*;
#(
  parameter int P  = 4,
  parameter int EW = 8,
  parameter int SW = EW + tree_levels(P)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [P*EW-1:0]      errs,
  output logic signed [SW-1:0] sum_q,
  output logic                 vld_q
);

  localparam int LV = tree_levels(P);
  localparam int PP = 1 << LV;

  logic signed [SW-1:0] leaf [P];
  logic signed [SW-1:0] sum_c;
  logic signed [SW-1:0] sum_d;

  // Sign-extend each lane error to the sum width.
  for (genvar i = 0; i < P; i++) begin : g_leaf
    assign leaf[i] = {{(SW-EW){errs[i*EW+EW-1]}}, errs[i*EW +: EW]};
  end

  // Balanced pairwise reduction over a zero-padded power-of-two set.
  always_comb begin
    logic signed [SW-1:0] t [PP];
    for (int k = 0; k < PP; k++) begin
      t[k] = (k < P) ? leaf[k] : '0;
    end
    for (int s = PP / 2; s > 0; s = s / 2) begin
      for (int k = 0; k < s; k++) begin
        t[k] = t[2*k] + t[2*k+1];
      end
    end
    sum_c = t[0];
  end

  assign sum_d = in_vld ? sum_c : sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sum_q <= sum_d;
      vld_q <= in_vld;
    end
  end

endmodule

// File: rtl/pi_filter.sv
module pi_filter #(
  parameter int SW    = 10,
  parameter int CW    = 9,
  parameter int KP_SH = 2,
  parameter int KI_SH = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld,
  input  logic signed [SW-1:0] sum,
  output logic signed [CW-1:0] w_c,
  output logic signed [CW-1:0] ctrl_q
);

  localparam int AW = ((SW > CW) ? SW : CW) + 2;
  localparam logic signed [AW-1:0] MAXV = AW'((64'sd1 <<< (CW-1)) - 64'sd1);
  localparam logic signed [AW-1:0] MINV = ~MAXV;

  logic signed [CW-1:0] integ_q;
  logic signed [CW-1:0] integ_d;
  logic signed [CW-1:0] integ_new;
  logic signed [CW-1:0] ctrl_d;
  logic signed [AW-1:0] sum_x;
  logic signed [AW-1:0] prop;
  logic signed [AW-1:0] ki;
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] w_raw;

  function automatic logic signed [CW-1:0] clip(input logic signed [AW-1:0] v);
    if (v > MAXV)      return MAXV[CW-1:0];
    else if (v < MINV) return MINV[CW-1:0];
    else               return v[CW-1:0];
  endfunction

  always_comb begin
    sum_x     = AW'(sum);
    prop      = sum_x >>> KP_SH;
    ki        = sum_x >>> KI_SH;
    acc       = AW'(integ_q) + ki;
    integ_new = clip(acc);
    w_raw     = prop + AW'(integ_new);
    w_c       = clip(w_raw);
    integ_d   = vld ? integ_new : integ_q;
    ctrl_d    = vld ? w_c : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
      ctrl_q  <= '0;
    end else begin
      integ_q <= integ_d;
      ctrl_q  <= ctrl_d;
    end
  end

endmodule

// File: rtl/nco_chain.sv
module nco_chain
  import tlc_pkg::*;
#(
  parameter int P    = 4,
  parameter int MUW  = 8,
  parameter int CW   = MUW + 1,
  parameter int N    = 1,
  parameter int IDXW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld,
  input  logic signed [CW-1:0] w,
  output logic [P*IDXW-1:0]    base_flat,
  output logic [P*MUW-1:0]     frac_flat,
  output logic                 out_vld
);

  localparam int ST1 = MUW + bits_for(N + 2) + 1;
  localparam int AVW = ST1 - MUW;
  localparam logic signed [ST1-1:0] NBASE = ST1'(N) <<< MUW;
  localparam logic [IDXW-1:0] WORD = IDXW'(P * N);

  logic [IDXW-1:0] carry_b_q, carry_b_d;
  logic [MUW-1:0]  carry_m_q, carry_m_d;
  logic [IDXW-1:0] lane_b [P];
  logic [MUW-1:0]  lane_m [P];
  logic [IDXW-1:0] base_q [P];
  logic [MUW-1:0]  frac_q [P];
  logic [IDXW-1:0] base_d [P];
  logic [MUW-1:0]  frac_d [P];

  // Chained per-lane advance: integer part from the high bits of the
  // step, next fraction from the low bits; no overflow comparison.
  always_comb begin
    logic [IDXW-1:0]      b;
    logic [MUW-1:0]       m;
    logic signed [ST1-1:0] wx;
    logic signed [ST1-1:0] mx;
    logic signed [ST1-1:0] st;
    logic [AVW-1:0]       adv;
    b  = carry_b_q;
    m  = carry_m_q;
    wx = ST1'(w);
    for (int i = 0; i < P; i++) begin
      lane_b[i] = b;
      lane_m[i] = m;
      mx  = ST1'({1'b0, m});
      st  = NBASE + wx + mx;
      adv = st[ST1-1:MUW];
      m   = st[MUW-1:0];
      b   = b + IDXW'(adv);
    end
    carry_b_d = vld ? (b - WORD) : carry_b_q;
    carry_m_d = vld ? m : carry_m_q;
    for (int i = 0; i < P; i++) begin
      base_d[i] = vld ? lane_b[i] : base_q[i];
      frac_d[i] = vld ? lane_m[i] : frac_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_b_q <= '0;
      carry_m_q <= '0;
      out_vld   <= 1'b0;
      for (int i = 0; i < P; i++) begin
        base_q[i] <= '0;
        frac_q[i] <= '0;
      end
    end else begin
      carry_b_q <= carry_b_d;
      carry_m_q <= carry_m_d;
      out_vld   <= vld;
      for (int i = 0; i < P; i++) begin
        base_q[i] <= base_d[i];
        frac_q[i] <= frac_d[i];
      end
    end
  end

  for (genvar i = 0; i < P; i++) begin : g_pack
    assign base_flat[i*IDXW +: IDXW] = base_q[i];
    assign frac_flat[i*MUW +: MUW]   = frac_q[i];
  end

endmodule

// File: rtl/timing_loop_ctrl.sv
module timing_loop_ctrl
  import tlc_pkg::*;
#(
  parameter int P     = 4,
  parameter int EW    = 8,
  parameter int MUW   = 8,
  parameter int N     = 1,
  parameter int IDXW  = 8,
  parameter int KP_SH = 2,
  parameter int KI_SH = 6,
  localparam int CW   = MUW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  input  logic [P*EW-1:0]   err_bus,
  output logic              out_valid,
  output logic [P*IDXW-1:0] base_idx,
  output logic [P*MUW-1:0]  frac,
  output logic [CW-1:0]     ctrl_word
);

  localparam int SW = EW + tree_levels(P);

  logic signed [SW-1:0] sum_q;
  logic                 sum_vld;
  logic signed [CW-1:0] w_c;
  logic signed [CW-1:0] ctrl_q;

  err_sum_tree #(.P(P), .EW(EW), .SW(SW)) u_sum (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (err_valid),
    .errs   (err_bus),
    .sum_q  (sum_q),
    .vld_q  (sum_vld)
  );

  pi_filter #(.SW(SW), .CW(CW), .KP_SH(KP_SH), .KI_SH(KI_SH)) u_pi (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld    (sum_vld),
    .sum    (sum_q),
    .w_c    (w_c),
    .ctrl_q (ctrl_q)
  );

  nco_chain #(.P(P), .MUW(MUW), .CW(CW), .N(N), .IDXW(IDXW)) u_nco (
    .clk       (clk),
    .rst_n     (rst_n),
    .vld       (sum_vld),
    .w         (w_c),
    .base_flat (base_idx),
    .frac_flat (frac),
    .out_vld   (out_valid)
  );

  assign ctrl_word = ctrl_q;

endmodule

// File: rtl/tlc_checker.sv
module tlc_checker #(
  parameter int P    = 4,
  parameter int MUW  = 8,
  parameter int N    = 1,
  parameter int IDXW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              err_valid,
  input logic              out_valid,
  input logic [P*IDXW-1:0] base_idx,
  input logic [P*MUW-1:0]  frac,
  input logic [MUW:0]      ctrl_word
);

  localparam int CW = MUW + 1;
  localparam int PW = IDXW + MUW;
  localparam logic [PW-1:0] NSTEP = PW'(N) << MUW;
  localparam logic [PW-1:0] WORDP = PW'(P * N) << MUW;

  logic [PW-1:0] w_ext;
  logic [PW-1:0] pos [P];
  logic [PW-1:0] last_q, w_prev_q, exp0;
  logic          seen_q;

  assign w_ext = {{(PW-CW){ctrl_word[CW-1]}}, ctrl_word};

  for (genvar i = 0; i < P; i++) begin : g_pos
    assign pos[i] = {base_idx[i*IDXW +: IDXW], frac[i*MUW +: MUW]};
  end

  assign exp0 = last_q + NSTEP + w_prev_q - WORDP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q   <= '0;
      w_prev_q <= '0;
      seen_q   <= 1'b0;
    end else if (out_valid) begin
      last_q   <= pos[P-1];
      w_prev_q <= w_ext;
      seen_q   <= 1'b1;
    end
  end

  // R5 / R6: neighbouring lanes are exactly N + w apart
  for (genvar i = 1; i < P; i++) begin : g_step
    p_lane_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((pos[i] - pos[i-1]) == (NSTEP + w_ext)));
  end

  p_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pos[0] == (seen_q ? exp0 : '0)));

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> ##1 out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(base_idx) && $stable(frac) && $stable(ctrl_word)));

endmodule

bind timing_loop_ctrl tlc_checker #(.P(P), .MUW(MUW), .N(N), .IDXW(IDXW)) u_tlc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .err_valid (err_valid),
  .out_valid (out_valid),
  .base_idx  (base_idx),
  .frac      (frac),
  .ctrl_word (ctrl_word)
);

// File: tb/tb_timing_loop_ctrl.sv
`timescale 1ns/1ps
module tb_timing_loop_ctrl;

  localparam int P = 4, EW = 8, MUW = 8, N = 1, IDXW = 8, KP = 2, KI = 6;
  localparam int CWB = MUW + 1;
  localparam int CMAX = (1 << MUW) - 1;
  localparam int CMIN = -(1 << MUW);
  localparam int IMASK = (1 << IDXW) - 1;
  localparam int FMASK = (1 << MUW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic err_valid;
  logic [P*EW-1:0] err_bus;
  logic out_valid;
  logic [P*IDXW-1:0] base_idx;
  logic [P*MUW-1:0] frac;
  logic [CWB-1:0] ctrl_word;

  int tests = 0, fails = 0;
  bit done = 0;
  int ev [P];
  int m_integ = 0, m_base = 0, m_mu = 0, m_w = 0;
  int e_base [P];
  int e_frac [P];

  always #2.5 clk = ~clk;

  timing_loop_ctrl dut (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_bus(err_bus),
    .out_valid(out_valid), .base_idx(base_idx), .frac(frac), .ctrl_word(ctrl_word)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clipv(input int v);
    if (v > CMAX) return CMAX;
    if (v < CMIN) return CMIN;
    return v;
  endfunction

  // Integer model of one transaction, built from R1-style arithmetic.
  task automatic model_step();
    int sum, prop, b, m, st;
    sum = 0;
    for (int i = 0; i < P; i++) sum += ev[i];
    prop    = sum >>> KP;
    m_integ = clipv(m_integ + (sum >>> KI));
    m_w     = clipv(prop + m_integ);
    b = m_base;
    m = m_mu;
    for (int i = 0; i < P; i++) begin
      e_base[i] = b & IMASK;
      e_frac[i] = m;
      st = (N << MUW) + m_w + m;
      b  = b + (st >>> MUW);
      m  = st & FMASK;
    end
    m_base = (b - P * N) & IMASK;
    m_mu   = m;
  endtask

  task automatic compare_all(input string ctag);
    chk(ctag, int'($signed(ctrl_word)), m_w);
    for (int i = 0; i < P; i++) begin
      if (i == 0) chk("R7", int'(base_idx[0 +: IDXW]), e_base[0]);
      else        chk("R6", int'(base_idx[i*IDXW +: IDXW]), e_base[i]);
      chk("R5", int'(frac[i*MUW +: MUW]), e_frac[i]);
    end
  endtask

  task automatic txn(input string ctag);
    for (int i = 0; i < P; i++) err_bus[i*EW +: EW] = EW'(ev[i]);
    err_valid = 1'b1;
    @(posedge clk); #1;
    err_valid = 1'b0;
    err_bus   = {P{8'h5A}};
    chk("R8", int'(out_valid), 0);
    @(posedge clk); #1;
    chk("R8", int'(out_valid), 1);
    model_step();
    compare_all(ctag);
  endtask

  task automatic set_all(input int v);
    for (int i = 0; i < P; i++) ev[i] = v;
  endtask

  task automatic idle_garbage(input int n);
    logic [P*IDXW-1:0] b0;
    logic [P*MUW-1:0]  f0;
    logic [CWB-1:0]    c0;
    b0 = base_idx; f0 = frac; c0 = ctrl_word;
    for (int k = 0; k < n; k++) begin
      err_bus = P*EW'(32'h7F80_13EC ^ (k * 32'h9E37));
      @(posedge clk); #1;
    end
    chk("R9", int'(out_valid), 0);
    chk("R9", int'(base_idx == b0), 1);
    chk("R9", int'(frac == f0), 1);
    chk("R9", int'(ctrl_word == c0), 1);
  endtask

  initial begin
    #(5ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; err_valid = 1'b0; err_bus = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R10: reset state
    chk("R10", int'(out_valid), 0);
    chk("R10", int'(ctrl_word), 0);
    chk("R10", int'(base_idx), 0);
    chk("R10", int'(frac), 0);

    // Nominal: zero error, lanes advance exactly N
    set_all(0); txn("R3");
    set_all(0); txn("R3");

    // R1: constant positive set, then a set whose last lane opposes the sum
    set_all(20); txn("R1");
    ev[0] = 100; ev[1] = 100; ev[2] = 100; ev[3] = -50; txn("R1");
    ev[0] = -90; ev[1] = -90; ev[2] = -90; ev[3] = 120; txn("R1");

    // R2/R3: ramped error sets of both signs
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < P; i++) ev[i] = ((k * 13 + i * 37) % 200) - 100;
      txn("R2");
    end

    // R9: garbage with valid low, then confirm state unchanged
    idle_garbage(5);
    set_all(3); txn("R9");

    // R4: drive integral to the upper limit, then reverse
    for (int k = 0; k < 60; k++) begin set_all(127); txn("R4"); end
    for (int k = 0; k < 4; k++) begin set_all(-128); txn("R4"); end
    // Lower limit: control word pinned negative, zero-advance lanes
    for (int k = 0; k < 80; k++) begin set_all(-128); txn("R4"); end
    set_all(127); txn("R4");

    // Back to small ramp to exercise carry after extremes
    for (int k = 0; k < 20; k++) begin
      for (int i = 0; i < P; i++) ev[i] = (k - 10) * (i + 1);
      txn("R3");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule